// File: doc/BRIEF.md
# Timeslot Subchannel Bit Packer

This block connects one 8-bit timeslot, which repeats once per frame, to a byte-oriented FIFO that feeds a bit-serial HDLC or transparent data path. Each frame is marked by a one-cycle strobe. On that strobe the receive side takes a contiguous group of bits out of the incoming timeslot byte and appends them, least significant bit first, to a byte being assembled. Each completed byte is offered to the FIFO. On the same strobe the transmit side takes the same number of bits from its current FIFO byte and places them into the outgoing timeslot byte. All other bit positions of that byte are driven to idle ones.

A channel configuration word selects the width of the group and its lowest bit position within the timeslot. It also sets whether data is inverted on its way out and whether transparent-mode transmission repeats the current byte instead of fetching new ones. A disabled channel touches neither FIFO. A narrow group carries only part of a 64 kbit/s timeslot. A D-channel, for example, uses two bits at position 0 for 16 kbit/s.

Top module: `subch_packer`

## Requirements
- R1: After reset, tx_ts_byte is 8'hFF, rx_push and tx_take are 0, and the configuration is all zero: 8 bits starting at bit 0, no inversion, no loop.
- R2: cfg_count selects the group width. Code 0 means 8 bits. Codes 1 to 7 mean that many bits per strobe.
- R3: cfg_start gives the lowest timeslot bit of the group, and the group extends upward from there. If start plus width exceeds 8, the group is clipped at bit 7.
- R4: Group bits enter the receive byte in order of rising timeslot position, filling from bit 0 of the byte upward. When 8 bits have gathered, rx_push is high for one cycle, the cycle after the strobe that completed the byte, with the byte on rx_data. Leftover bits start the next byte.
- R5: In the cycle after an enabled strobe, tx_ts_byte carries the next transmit bits in group positions, taken from bit 0 of the FIFO byte upward, with 1 in every position outside the group. Between strobes, tx_ts_byte holds its value.
- R6: tx_take is high, only during an enabled strobe, exactly when the bits left of the current transmit byte are fewer than the group width. The FIFO head (tx_data) is then consumed in that cycle, and at most one byte is taken per strobe.
- R7: With cfg_invert set, both the bytes pushed on rx_data and the group bits in tx_ts_byte are complemented.
- R8: With cfg_loop set and mode_transparent high, once a byte has been fetched it is resent repeatedly and no further tx_take occurs. With mode_transparent low, cfg_loop has no effect.
- R9: A strobe with ch_en low causes no rx_push and no tx_take, drives tx_ts_byte to 8'hFF, and leaves the partial bytes of both directions untouched.
- R10: A configuration write (cfg_we) discards both partial bytes and the loop byte, and sets tx_ts_byte to 8'hFF. A strobe in the same cycle is dropped.
- R11: If a byte is needed while tx_valid is low, and no loop byte applies, all-ones bits are sent instead and tx_take stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load configuration fields |
| cfg_count | input | 3 | Group width code (0 = 8 bits) |
| cfg_start | input | 3 | Lowest bit position of the group |
| cfg_invert | input | 1 | Complement outgoing data |
| cfg_loop | input | 1 | Repeat current transmit byte in transparent mode |
| mode_transparent | input | 1 | 1 = transparent path, 0 = HDLC path |
| ch_en | input | 1 | Channel enable |
| ts_strobe | input | 1 | One-cycle frame strobe |
| rx_ts_byte | input | 8 | Incoming timeslot byte, valid with strobe |
| rx_push | output | 1 | Packed receive byte valid (one cycle) |
| rx_data | output | 8 | Packed receive byte |
| tx_data | input | 8 | Head byte of the transmit FIFO |
| tx_valid | input | 1 | tx_data holds a byte |
| tx_take | output | 1 | Consume tx_data this cycle |
| tx_ts_byte | output | 8 | Outgoing timeslot byte |

## Verification
A single strobe can complete a receive byte and fetch a new transmit byte at once. This happens whenever the group width does not divide 8 and both directions cross a byte boundary together, for example with a width of 3. The bench runs odd widths directed and random, with the FIFO sometimes empty. At each strobe it predicts, from separate bit-queue models, whether a push and a take occur and what values they carry. It then compares the pushed byte, the timeslot output and the number of bytes consumed in the same cycle.

// File: rtl/subch_pkg.sv
package subch_pkg;
  localparam int TS_W = 8;
  localparam int CW   = $clog2(TS_W);

  typedef struct packed {
    logic [CW-1:0] count;
    logic [CW-1:0] start;
    logic          invert;
    logic          loop;
  } subch_cfg_t;
endpackage

// File: rtl/subch_cfg.sv
module subch_cfg
  import subch_pkg::*;
#(
  parameter int W   = TS_W,
  localparam int CB = $clog2(W),
  localparam int EB = CB + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  subch_cfg_t    wr_cfg,
  output subch_cfg_t    cfg,
  output logic [EB-1:0] eff
);
  logic [EB-1:0] width, room;

  always_ff @(posedge clk) begin
    if (rst)     cfg <= '0;
    else if (we) cfg <= wr_cfg;
  end

  always_comb begin
    width = (cfg.count == '0) ? EB'(W) : EB'(cfg.count);
    room  = EB'(W) - EB'(cfg.start);
    eff   = (width < room) ? width : room;
  end

  assert_eff_range_R3: assert property (@(posedge clk) disable iff (rst)
    (eff != '0) && ({1'b0, eff} + EB'(cfg.start) <= (EB+1)'(W)));
endmodule

// File: rtl/subch_rx.sv
module subch_rx #(
  parameter int W   = 8,
  localparam int CB = $clog2(W),
  localparam int EB = CB + 1,
  localparam int TB = CB + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  input  logic [W-1:0]  ts_in,
  input  logic [CB-1:0] start,
  input  logic [EB-1:0] eff,
  input  logic          inv,
  output logic          push,
  output logic [W-1:0]  data
);
  logic [W-1:0]   acc, mask, slice;
  logic [CB-1:0]  fill;
  logic [2*W-1:0] joined;
  logic [TB-1:0]  total;

  always_comb begin
    for (int i = 0; i < W; i++) mask[i] = (i < int'(eff));
    slice  = (ts_in >> start) & mask;
    joined = {{W{1'b0}}, acc} | ({{W{1'b0}}, slice} << fill);
    total  = TB'(fill) + TB'(eff);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc  <= '0;
      fill <= '0;
      push <= 1'b0;
      data <= '0;
    end else begin
      push <= 1'b0;
      if (step) begin
        if (total >= TB'(W)) begin
          push <= 1'b1;
          data <= joined[W-1:0] ^ {W{inv}};
          acc  <= joined[2*W-1:W];
          fill <= CB'(total - TB'(W));
        end else begin
          acc  <= joined[W-1:0];
          fill <= CB'(total);
        end
      end
    end
  end

  assert_fill_clean_R4: assert property (@(posedge clk) disable iff (rst)
    (acc >> fill) == '0);
endmodule

// File: rtl/subch_tx.sv
module subch_tx #(
  parameter int W   = 8,
  localparam int CB = $clog2(W),
  localparam int EB = CB + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          strobe,
  input  logic          en,
  input  logic [CB-1:0] start,
  input  logic [EB-1:0] eff,
  input  logic          inv,
  input  logic          loop_act,
  input  logic [W-1:0]  fifo_data,
  input  logic          fifo_valid,
  output logic          take,
  output logic [W-1:0]  ts_out
);
  logic [W-1:0]   cur, last, src, mask, slice, winmask, out_n;
  logic [EB-1:0]  q;
  logic [EB:0]    qa, qn;
  logic           have_last, need, use_fifo;
  logic [2*W-1:0] avail, rest;

  always_comb begin
    for (int i = 0; i < W; i++) mask[i] = (i < int'(eff));
    need     = strobe && en && (q < eff);
    use_fifo = !(loop_act && have_last) && fifo_valid;
    if (loop_act && have_last) src = last;
    else if (fifo_valid)       src = fifo_data;
    else                       src = '1;
    take = need && use_fifo;
    if (need) begin
      avail = {{W{1'b0}}, cur} | ({{W{1'b0}}, src} << q);
      qa    = (EB+1)'(q) + (EB+1)'(W);
    end else begin
      avail = {{W{1'b0}}, cur};
      qa    = (EB+1)'(q);
    end
    slice   = avail[W-1:0] & mask;
    rest    = avail >> eff;
    qn      = qa - (EB+1)'(eff);
    winmask = mask << start;
    out_n   = ~winmask | (((slice ^ {W{inv}}) & mask) << start);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cur       <= '0;
      q         <= '0;
      last      <= '0;
      have_last <= 1'b0;
      ts_out    <= '1;
    end else if (strobe) begin
      if (en) begin
        cur    <= rest[W-1:0];
        q      <= EB'(qn);
        ts_out <= out_n;
        if (take) begin
          last      <= fifo_data;
          have_last <= 1'b1;
        end
      end else begin
        ts_out <= '1;
      end
    end
  end

  assert_take_valid_R11: assert property (@(posedge clk) disable iff (rst)
    take |-> fifo_valid);
  assert_take_in_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    take |-> (strobe && en));
  assert_loop_no_take_R8: assert property (@(posedge clk) disable iff (rst)
    (loop_act && have_last) |-> !take);
  assert_queue_range_R6: assert property (@(posedge clk) disable iff (rst)
    q < EB'(W));
endmodule

// File: rtl/subch_packer.sv
module subch_packer
  import subch_pkg::*;
#(
  parameter int W   = TS_W,
  localparam int CB = $clog2(W),
  localparam int EB = CB + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [CB-1:0] cfg_count,
  input  logic [CB-1:0] cfg_start,
  input  logic          cfg_invert,
  input  logic          cfg_loop,
  input  logic          mode_transparent,
  input  logic          ch_en,
  input  logic          ts_strobe,
  input  logic [W-1:0]  rx_ts_byte,
  output logic          rx_push,
  output logic [W-1:0]  rx_data,
  input  logic [W-1:0]  tx_data,
  input  logic          tx_valid,
  output logic          tx_take,
  output logic [W-1:0]  tx_ts_byte
);
  subch_cfg_t    wr_cfg, cfg;
  logic [EB-1:0] eff;
  logic          strobe_ok;

  assign wr_cfg    = '{count: cfg_count, start: cfg_start, invert: cfg_invert, loop: cfg_loop};
  assign strobe_ok = ts_strobe && !cfg_we;

  subch_cfg #(.W(W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wr_cfg(wr_cfg), .cfg(cfg), .eff(eff)
  );

  subch_rx #(.W(W)) u_rx (
    .clk(clk), .rst(rst), .clr(cfg_we), .step(strobe_ok && ch_en),
    .ts_in(rx_ts_byte), .start(cfg.start), .eff(eff), .inv(cfg.invert),
    .push(rx_push), .data(rx_data)
  );

  subch_tx #(.W(W)) u_tx (
    .clk(clk), .rst(rst), .clr(cfg_we), .strobe(strobe_ok), .en(ch_en),
    .start(cfg.start), .eff(eff), .inv(cfg.invert),
    .loop_act(cfg.loop && mode_transparent),
    .fifo_data(tx_data), .fifo_valid(tx_valid),
    .take(tx_take), .ts_out(tx_ts_byte)
  );

  assert_push_after_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> $past(ts_strobe && ch_en && !cfg_we));
  assert_idle_disabled_R9: assert property (@(posedge clk) disable iff (rst)
    $past(ts_strobe && !ch_en) |-> (tx_ts_byte == '1 && !rx_push));
  assert_hold_between_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(ts_strobe) && !$past(cfg_we)) |-> $stable(tx_ts_byte));
  assert_disabled_no_take_R9: assert property (@(posedge clk) disable iff (rst)
    !ch_en |-> !tx_take);
endmodule

// File: tb/tb_subch_packer.sv
module tb_subch_packer;
  logic       clk = 1'b0, rst = 1'b1;
  logic       cfg_we = 0, cfg_invert = 0, cfg_loop = 0, mode_transparent = 0;
  logic [2:0] cfg_count = 0, cfg_start = 0;
  logic       ch_en = 1, ts_strobe = 0;
  logic [7:0] rx_ts_byte = 0;
  logic       rx_push, tx_take, tx_valid;
  logic [7:0] rx_data, tx_data, tx_ts_byte;

  logic [7:0] fifo_mem [256];
  logic [7:0] rd = 0, wr = 0, mrd = 0;
  assign tx_data  = fifo_mem[rd];
  assign tx_valid = (rd != wr);
  always @(posedge clk) if (tx_take) rd <= rd + 8'd1;

  always #2 clk = ~clk;

  subch_packer dut (.*);

  int vectors = 0, errors = 0;
  bit rxq[$], txq[$];
  logic [2:0] m_cnt = 0, m_start = 0;
  bit m_inv = 0, m_loop = 0, m_have = 0;
  logic [7:0] m_last = 0;

  function automatic int eff_of(logic [2:0] c, logic [2:0] s);
    int n = (c == 0) ? 8 : int'(c);
    return (n < 8 - int'(s)) ? n : 8 - int'(s);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(logic [7:0] b);
    fifo_mem[wr] = b;
    wr = wr + 8'd1;
  endtask

  task automatic set_cfg(logic [2:0] c, logic [2:0] s, bit inv, bit lp);
    @(negedge clk);
    cfg_we = 1; cfg_count = c; cfg_start = s; cfg_invert = inv; cfg_loop = lp;
    @(negedge clk);
    cfg_we = 0;
    m_cnt = c; m_start = s; m_inv = inv; m_loop = lp; m_have = 0;
    rxq.delete(); txq.delete();
    chk(tx_ts_byte == 8'hFF, "R10 idle after cfg", tx_ts_byte, 8'hFF);
  endtask

  task automatic strobe(logic [7:0] rxb, string tag);
    int e;
    logic [7:0] exp_tx, exp_rx, b;
    bit exp_push;
    e = eff_of(m_cnt, m_start);
    exp_tx = 8'hFF; exp_push = 0; exp_rx = 0;
    if (ch_en) begin
      for (int i = 0; i < e; i++) rxq.push_back(rxb[int'(m_start) + i]);
      if (rxq.size() >= 8) begin
        exp_push = 1;
        for (int i = 0; i < 8; i++) exp_rx[i] = rxq.pop_front();
        exp_rx ^= {8{m_inv}};
      end
      if (txq.size() < e) begin
        if (m_loop && mode_transparent && m_have) b = m_last;
        else if (mrd != wr) begin
          b = fifo_mem[mrd]; mrd = mrd + 8'd1; m_last = b; m_have = 1;
        end else b = 8'hFF;
        for (int i = 0; i < 8; i++) txq.push_back(b[i]);
      end
      for (int i = 0; i < e; i++) exp_tx[int'(m_start) + i] = txq.pop_front() ^ m_inv;
    end
    @(negedge clk);
    ts_strobe = 1; rx_ts_byte = rxb;
    @(negedge clk);
    ts_strobe = 0;
    chk(tx_ts_byte == exp_tx, {tag, "/R5 tx byte"}, tx_ts_byte, exp_tx);
    chk(rx_push == exp_push, {tag, "/R4 push"}, rx_push, exp_push);
    if (exp_push) chk(rx_data == exp_rx, {tag, "/R4 rx byte"}, rx_data, exp_rx);
    chk(rd == mrd, {tag, "/R6 bytes taken"}, rd, mrd);
    repeat (2) @(negedge clk);
    chk(!rx_push, {tag, "/R4 single pulse"}, rx_push, 0);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(tx_ts_byte == 8'hFF, "R1 tx reset", tx_ts_byte, 8'hFF);
    chk(!rx_push, "R1 push reset", rx_push, 0);
    chk(!tx_take, "R1 take reset", tx_take, 0);

    // R1/R2: default configuration is 8 bits at bit 0
    for (int i = 0; i < 4; i++) put(8'h30 + 8'(i));
    for (int i = 0; i < 4; i++) strobe(8'(8'hA5 + i), "R1 default 8 bit");

    // R2: two-bit group at bit 0
    set_cfg(3'd2, 3'd0, 0, 0);
    put(8'hC6); put(8'h1B);
    for (int i = 0; i < 8; i++) strobe(8'($urandom), "R2 two bit");

    // R3: clipping, start 6 width 5 gives 2 bits
    set_cfg(3'd5, 3'd6, 0, 0);
    put(8'h96);
    for (int i = 0; i < 6; i++) strobe(8'($urandom), "R3 clip");

    // R4/R6: width 3 at bit 2, push and take coincide
    set_cfg(3'd3, 3'd2, 0, 0);
    for (int i = 0; i < 4; i++) put(8'($urandom));
    for (int i = 0; i < 10; i++) strobe(8'($urandom), "R4 odd width");

    // R7: inversion
    set_cfg(3'd0, 3'd0, 1, 0);
    put(8'h0F); put(8'h5A);
    for (int i = 0; i < 3; i++) strobe(8'($urandom), "R7 invert");

    // R8: loop in transparent mode, then loop ignored in HDLC mode
    mode_transparent = 1;
    set_cfg(3'd4, 3'd1, 0, 1);
    put(8'hE1); put(8'h77); put(8'h88);
    for (int i = 0; i < 8; i++) strobe(8'($urandom), "R8 loop transparent");
    mode_transparent = 0;
    set_cfg(3'd4, 3'd1, 0, 1);
    for (int i = 0; i < 6; i++) strobe(8'($urandom), "R8 loop hdlc");

    // R11: underrun with FIFO empty
    set_cfg(3'd6, 3'd0, 0, 0);
    for (int i = 0; i < 4; i++) strobe(8'($urandom), "R11 underrun");

    // R9: disabled strobes keep partial bytes
    set_cfg(3'd3, 3'd0, 0, 0);
    put(8'h3C); put(8'hC3);
    strobe(8'h05, "R9 before");
    ch_en = 0;
    for (int i = 0; i < 3; i++) strobe(8'($urandom), "R9 disabled");
    ch_en = 1;
    for (int i = 0; i < 5; i++) strobe(8'($urandom), "R9 resumed");

    // R10: a config write drops the partial byte
    set_cfg(3'd5, 3'd0, 0, 0);
    put(8'h81);
    strobe(8'h1F, "R10 partial");
    set_cfg(3'd5, 3'd0, 0, 0);
    put(8'h42); put(8'h24);
    for (int i = 0; i < 4; i++) strobe(8'($urandom), "R10 after clear");

    // random mix
    for (int k = 0; k < 60; k++) begin
      mode_transparent = 1'($urandom);
      set_cfg(3'($urandom), 3'($urandom), 1'($urandom), 1'($urandom));
      for (int i = 0; i < 20; i++) begin
        if (($urandom % 4) != 0 && (wr - rd) < 8'd64) put(8'($urandom));
        ch_en = (($urandom % 8) != 0);
        strobe(8'($urandom), "R2 R3 random");
      end
      ch_en = 1;
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule